// File: doc/BRIEF.md
# Serial Frame Transmitter with Optional Bit Clock

This block serializes bytes onto a single transmit line. Each frame is a low start bit, the data bits least significant first, and a high stop period whose length is 0.5, 1, 1.5 or 2 bit times. All timing comes from an enable input that pulses sixteen times per bit. A byte is offered with a valid/ready handshake and is taken only while the transmitter is idle.

Two extra functions sit beside the frame engine. In line-bus mode, a break request drives the line low for thirteen bit times. The line then returns high for at least one bit time, and a one-cycle completion pulse follows. The second function is an optional bit clock output for synchronous receivers. This clock pulses once per data bit, and its rest level and capture edge are selectable. The control word is latched when a frame or break begins, so changing the control word part way through a frame has no effect on that frame.

Top module: `sstx_top`

## Requirements
- R1: After reset, tx_o is high, busy_o and brk_done_o are low and ready_o is high. Whenever busy_o is low, tx_o is high.
- R2: A frame is a start bit held low for 16 ticks, followed by 8 data bits least significant first, each held for 16 ticks.
- R3: Control bits [4:3] select the stop period, during which tx_o is high: 00 gives 16 ticks, 01 gives 8 ticks, 10 gives 32 ticks and 11 gives 24 ticks.
- R4: A byte is accepted only in a cycle where valid_i and ready_o are both high. This happens only while busy_o is low, and ready_o stays low for the whole frame. In the cycle after acceptance, busy_o is high and tx_o is low.
- R5: The control word is sampled in the acceptance cycle. A change made during a frame does not alter that frame.
- R6: With control bit 5 (line-bus mode) set in the cycle brk_req_i pulses, tx_o goes low for exactly 208 ticks. It is then high for at least 16 ticks, after which brk_done_o pulses for one cycle while tx_o is high and busy_o is low.
- R7: A brk_req_i pulse while control bit 5 is clear is dropped. tx_o stays high and no brk_done_o pulse occurs.
- R8: A break that is pending when a frame ends is sent before any waiting byte.
- R9: With control bit 2 (clock enable) clear, sclk_o stays at the level given by control bit 1 during the whole frame.
- R10: While idle, sclk_o rests at the level of control bit 1 (0 = rests low, 1 = rests high).
- R11: With the clock enabled, sclk_o makes exactly one pulse per data bit and none during the start or stop bits. With control bit 0 clear, the pulse occupies ticks 8 to 15 of each bit. With it set, the pulse occupies ticks 0 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_i | input | 6 | Control word: [5] line-bus mode, [4:3] stop code, [2] clock enable, [1] clock rest level, [0] clock phase |
| data_i | input | DATA_W | Byte to send |
| valid_i | input | 1 | data_i is offered |
| ready_o | output | 1 | Byte is taken this cycle if valid_i is high |
| brk_req_i | input | 1 | One-cycle break request |
| tick_i | input | 1 | Enable pulse, sixteen per bit |
| tx_o | output | 1 | Serial transmit line |
| sclk_o | output | 1 | Optional bit clock |
| busy_o | output | 1 | Frame or break in progress |
| brk_done_o | output | 1 | One-cycle pulse when a break has finished |

## Verification
On every cycle, the assertions check the handshake rules: a byte is accepted only while idle, the start bit follows at once, the line is high while idle, and the break completion pulse is a single cycle that lands on an idle, high line. They also check that the idle clock level follows the selected polarity. Only the bench's scenarios can show the tick lengths of the start, data, stop and break periods, the bit order, and where the clock pulse sits inside each bit. The same holds for the cases where a break request is dropped, where a pending break wins over a waiting byte, and where a control change during a frame leaves that frame unchanged.

// File: rtl/sstx_pkg.sv
package sstx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_START = 3'd1,
      ST_DATA  = 3'd2,
      ST_STOP  = 3'd3,
      ST_BREAK = 3'd4,
      ST_GAP   = 3'd5
   } sstx_state_e;

   // Control word layout, most significant field first
   typedef struct packed {
      logic       line_mode;
      logic [1:0] stop_code;
      logic       clk_en;
      logic       clk_pol;
      logic       clk_pha;
   } sstx_ctrl_t;

   localparam int CTRL_W = $bits(sstx_ctrl_t);

   localparam logic [1:0] STOP_ONE     = 2'b00;
   localparam logic [1:0] STOP_HALF    = 2'b01;
   localparam logic [1:0] STOP_TWO     = 2'b10;
   localparam logic [1:0] STOP_ONEHALF = 2'b11;

endpackage

// File: rtl/sstx_period_sel.sv
module sstx_period_sel
   import sstx_pkg::*;
#(
   parameter int OVS        = 16,
   parameter int BREAK_BITS = 13,
   parameter int CNT_W      = 8
) (
   input  sstx_state_e        state_i,
   input  logic [1:0]         stop_i,
   output logic [CNT_W-1:0]   last_o
);

   localparam logic [CNT_W-1:0] L_BIT     = CNT_W'(OVS - 1);
   localparam logic [CNT_W-1:0] L_HALF    = CNT_W'(OVS / 2 - 1);
   localparam logic [CNT_W-1:0] L_TWO     = CNT_W'(2 * OVS - 1);
   localparam logic [CNT_W-1:0] L_ONEHALF = CNT_W'(OVS + OVS / 2 - 1);
   localparam logic [CNT_W-1:0] L_BREAK   = CNT_W'(BREAK_BITS * OVS - 1);

   logic [CNT_W-1:0] stop_last;

   always_comb begin
      case (stop_i)
         STOP_HALF:    stop_last = L_HALF;
         STOP_TWO:     stop_last = L_TWO;
         STOP_ONEHALF: stop_last = L_ONEHALF;
         default:      stop_last = L_BIT;
      endcase
   end

   always_comb begin
      case (state_i)
         ST_STOP:  last_o = stop_last;
         ST_BREAK: last_o = L_BREAK;
         default:  last_o = L_BIT;
      endcase
   end

endmodule

// File: rtl/sstx_seq.sv
module sstx_seq
   import sstx_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int OVS        = 16,
   parameter int BREAK_BITS = 13,
   parameter int CNT_W      = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  sstx_ctrl_t        ctrl_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              valid_i,
   output logic              ready_o,
   input  logic              brk_req_i,
   input  logic              tick_i,
   output logic              tx_o,
   output logic              busy_o,
   output logic              brk_done_o,
   output logic              in_data_o,
   output logic [CNT_W-1:0]  cnt_o,
   output logic              clk_en_o,
   output logic              clk_pol_o,
   output logic              clk_pha_o
);

   localparam int BIDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [BIDX_W-1:0] LAST_BIT = BIDX_W'(DATA_W - 1);

   sstx_state_e       state;
   logic [CNT_W-1:0]  cnt;
   logic [CNT_W-1:0]  cnt_last;
   logic [BIDX_W-1:0] bit_idx;
   logic [DATA_W-1:0] shreg;
   logic [1:0]        stop_q;
   logic              ce_q, pol_q, pha_q;
   logic              brk_pend;
   logic              done_q;
   logic              period_end;

   sstx_period_sel #(
      .OVS        (OVS),
      .BREAK_BITS (BREAK_BITS),
      .CNT_W      (CNT_W)
   ) u_period (
      .state_i (state),
      .stop_i  (stop_q),
      .last_o  (cnt_last)
   );

   assign period_end = tick_i && (cnt == cnt_last);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state    <= ST_IDLE;
         cnt      <= '0;
         bit_idx  <= '0;
         shreg    <= '0;
         stop_q   <= STOP_ONE;
         ce_q     <= 1'b0;
         pol_q    <= 1'b0;
         pha_q    <= 1'b0;
         brk_pend <= 1'b0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (brk_req_i && ctrl_i.line_mode) brk_pend <= 1'b1;
         if (state == ST_IDLE) begin
            stop_q  <= ctrl_i.stop_code;
            ce_q    <= ctrl_i.clk_en;
            pol_q   <= ctrl_i.clk_pol;
            pha_q   <= ctrl_i.clk_pha;
            cnt     <= '0;
            bit_idx <= '0;
            if (brk_pend) begin
               brk_pend <= 1'b0;
               state    <= ST_BREAK;
            end else if (valid_i) begin
               shreg <= data_i;
               state <= ST_START;
            end
         end else if (tick_i) begin
            if (!period_end) begin
               cnt <= cnt + 1'b1;
            end else begin
               cnt <= '0;
               case (state)
                  ST_START: state <= ST_DATA;
                  ST_DATA: begin
                     shreg <= shreg >> 1;
                     if (bit_idx == LAST_BIT) state <= ST_STOP;
                     else bit_idx <= bit_idx + 1'b1;
                  end
                  ST_BREAK: state <= ST_GAP;
                  ST_GAP: begin
                     done_q <= 1'b1;
                     state  <= ST_IDLE;
                  end
                  default: state <= ST_IDLE;
               endcase
            end
         end
      end
   end

   always_comb begin
      case (state)
         ST_START, ST_BREAK: tx_o = 1'b0;
         ST_DATA:            tx_o = shreg[0];
         default:            tx_o = 1'b1;
      endcase
   end

   assign ready_o    = (state == ST_IDLE) && !brk_pend;
   assign busy_o     = (state != ST_IDLE);
   assign brk_done_o = done_q;
   assign in_data_o  = (state == ST_DATA);
   assign cnt_o      = cnt;
   assign clk_en_o   = ce_q;
   assign clk_pol_o  = pol_q;
   assign clk_pha_o  = pha_q;

endmodule

// File: rtl/sstx_sclk_gen.sv
module sstx_sclk_gen #(
   parameter int OVS      = 16,
   parameter int CNT_W    = 8,
   parameter bit SCLK_REG = 1'b0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             in_data_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic             en_i,
   input  logic             pol_i,
   input  logic             pha_i,
   output logic             sclk_o
);

   localparam logic [CNT_W-1:0] HALF = CNT_W'(OVS / 2);

   logic late_half;
   logic active;
   logic level;

   assign late_half = (cnt_i >= HALF);
   assign active    = in_data_i && (pha_i ? !late_half : late_half);
   assign level     = pol_i ^ (en_i & active);

   generate
      if (SCLK_REG) begin : g_reg
         logic sclk_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) sclk_q <= 1'b0;
            else         sclk_q <= level;
         end
         assign sclk_o = sclk_q;
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk_i ^ rst_ni;
         assign sclk_o = level;
      end
   endgenerate

endmodule

// File: rtl/sstx_top.sv
module sstx_top
   import sstx_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int OVS        = 16,
   parameter int BREAK_BITS = 13,
   parameter bit SCLK_REG   = 1'b0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [5:0]        ctrl_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              valid_i,
   output logic              ready_o,
   input  logic              brk_req_i,
   input  logic              tick_i,
   output logic              tx_o,
   output logic              sclk_o,
   output logic              busy_o,
   output logic              brk_done_o
);

   localparam int CNT_W = $clog2(BREAK_BITS * OVS + 1);

   generate
      if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("sstx_top: OVS must be even and at least 4");
      end
      if (BREAK_BITS < 2) begin : g_bad_brk
         $error("sstx_top: BREAK_BITS must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("sstx_top: DATA_W must be at least 1");
      end
      if (CTRL_W != 6) begin : g_bad_ctrl
         $error("sstx_top: control word width mismatch");
      end
   endgenerate

   sstx_ctrl_t       ctrl_s;
   logic             in_data;
   logic [CNT_W-1:0] cnt;
   logic             ce, pol, pha;

   assign ctrl_s = ctrl_i;

   sstx_seq #(
      .DATA_W     (DATA_W),
      .OVS        (OVS),
      .BREAK_BITS (BREAK_BITS),
      .CNT_W      (CNT_W)
   ) u_seq (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ctrl_i     (ctrl_s),
      .data_i     (data_i),
      .valid_i    (valid_i),
      .ready_o    (ready_o),
      .brk_req_i  (brk_req_i),
      .tick_i     (tick_i),
      .tx_o       (tx_o),
      .busy_o     (busy_o),
      .brk_done_o (brk_done_o),
      .in_data_o  (in_data),
      .cnt_o      (cnt),
      .clk_en_o   (ce),
      .clk_pol_o  (pol),
      .clk_pha_o  (pha)
   );

   sstx_sclk_gen #(
      .OVS      (OVS),
      .CNT_W    (CNT_W),
      .SCLK_REG (SCLK_REG)
   ) u_sclk (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .in_data_i (in_data),
      .cnt_i     (cnt),
      .en_i      (ce),
      .pol_i     (pol),
      .pha_i     (pha),
      .sclk_o    (sclk_o)
   );

endmodule

// File: rtl/sstx_chk.sv
module sstx_chk (
   input logic       clk_i,
   input logic       rst_ni,
   input logic [5:0] ctrl_i,
   input logic       valid_i,
   input logic       ready_o,
   input logic       tx_o,
   input logic       sclk_o,
   input logic       busy_o,
   input logic       brk_done_o
);

   logic armed;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) armed <= 1'b0;
      else         armed <= 1'b1;
   end

   a_r1_idle_line_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_o |-> tx_o);

   a_r4_accept_only_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && ready_o) |-> !busy_o);

   a_r4_start_follows_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && ready_o) |=> (busy_o && !tx_o));

   a_r6_done_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      brk_done_o |=> !brk_done_o);

   a_r6_done_on_idle_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
      brk_done_o |-> (tx_o && !busy_o));

   a_r10_rest_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (armed && !busy_o && $past(!busy_o)) |-> (sclk_o == $past(ctrl_i[1])));

endmodule

bind sstx_top sstx_chk u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .ctrl_i     (ctrl_i),
   .valid_i    (valid_i),
   .ready_o    (ready_o),
   .tx_o       (tx_o),
   .sclk_o     (sclk_o),
   .busy_o     (busy_o),
   .brk_done_o (brk_done_o)
);

// File: tb/sstx_top_test.sv
module sstx_top_test;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic [5:0] ctrl  = '0;
   logic [7:0] data  = '0;
   logic       valid = 1'b0;
   logic       brk   = 1'b0;
   logic       tick  = 1'b0;
   logic       ready, tx, sclk, busy, done;

   sstx_top uut (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .ctrl_i     (ctrl),
      .data_i     (data),
      .valid_i    (valid),
      .ready_o    (ready),
      .brk_req_i  (brk),
      .tick_i     (tick),
      .tx_o       (tx),
      .sclk_o     (sclk),
      .busy_o     (busy),
      .brk_done_o (done)
   );

   int nchk = 0, nfail = 0;
   int nlog = 0, ndone = 0, done_at = -1;
   bit finished = 1'b0;
   logic ltx [4096];
   logic lsc [4096];

   // vector: {clk_en, clk_pol, clk_pha, stop[1:0], data[7:0], stop_ticks[7:0]}
   localparam logic [20:0] VEC [6] = '{
      {1'b1, 1'b0, 1'b0, 2'b00, 8'hA5, 8'd16},
      {1'b1, 1'b1, 1'b0, 2'b01, 8'h3C, 8'd8},
      {1'b1, 1'b0, 1'b1, 2'b10, 8'h96, 8'd32},
      {1'b1, 1'b1, 1'b1, 2'b11, 8'h01, 8'd24},
      {1'b0, 1'b1, 1'b0, 2'b00, 8'hF0, 8'd16},
      {1'b0, 1'b0, 1'b1, 2'b11, 8'h5A, 8'd24}
   };

   // tick enable: one cycle in four
   initial begin
      int ph = 0;
      forever begin
         @(negedge clk);
         tick = ((ph % 4) == 3);
         ph++;
      end
   end

   // per-tick log of the line and the clock pin
   always begin
      @(negedge clk);
      #1;
      if (done) begin
         ndone++;
         done_at = nlog;
      end
      if (tick && nlog < 4096) begin
         ltx[nlog] = tx;
         lsc[nlog] = sclk;
         nlog++;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int find_low(input int from);
      for (int k = from; k < nlog; k++) if (ltx[k] == 1'b0) return k;
      return -1;
   endfunction

   function automatic int run_len(input int from, input logic v);
      int n = 0;
      for (int k = from; k < nlog; k++) begin
         if (ltx[k] != v) return n;
         n++;
      end
      return n;
   endfunction

   task automatic clear_log();
      nlog = 0;
      ndone = 0;
      done_at = -1;
   endtask

   task automatic send(input logic [7:0] d);
      data = d;
      valid = 1'b1;
      while (!ready) @(negedge clk);
      @(negedge clk);
      valid = 1'b0;
   endtask

   task automatic wait_idle();
      repeat (4) @(negedge clk);
      while (busy) @(negedge clk);
      repeat (8) @(negedge clk);
   endtask

   task automatic pulse_break();
      brk = 1'b1;
      @(negedge clk);
      brk = 1'b0;
   endtask

   initial begin
      #1_500_000;
      if (!finished) begin
         nfail++;
         $display("FAIL watchdog (all requirements): actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
         $finish;
      end
   end

   initial begin
      logic ce, cp, cph;
      logic [1:0] st;
      logic [7:0] d;
      int exps, s, p, edges, s2, s3;

      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 tx after reset", int'(tx), 1);
      chk("R1 busy after reset", int'(busy), 0);
      chk("R1 ready after reset", int'(ready), 1);
      chk("R1 brk_done after reset", int'(done), 0);
      chk("R10 sclk rests low after reset", int'(sclk), 0);

      // table walk: R2 R3 R9 R10 R11
      for (int v = 0; v < 6; v++) begin
         {ce, cp, cph, st, d} = VEC[v][20:8];
         exps = int'(VEC[v][7:0]);
         ctrl = {1'b0, st, ce, cp, cph};
         repeat (3) @(negedge clk);
         chk($sformatf("R10 idle sclk level v%0d", v), int'(sclk), int'(cp));
         clear_log();
         send(d);
         send(8'hFF);
         wait_idle();
         s = find_low(0);
         chk($sformatf("R2 start found v%0d", v), int'(s >= 0), 1);
         if (s < 0) s = 0;
         chk($sformatf("R2 start held low v%0d", v), int'(ltx[s + 15]), 0);
         for (int i = 0; i < 8; i++)
            chk($sformatf("R2 data bit %0d v%0d", i, v), int'(ltx[s + 24 + 16 * i]), int'(d[i]));
         p = s + 144;
         chk($sformatf("R3 stop ticks code %0d v%0d", st, v), run_len(p, 1'b1), exps);
         edges = 0;
         for (int k = s + 1; k < p + exps; k++)
            if (lsc[k] != lsc[k - 1] && lsc[k] != cp) edges++;
         chk($sformatf("R11 pulse count v%0d", v), edges, ce ? 8 : 0);
         chk($sformatf("R11 no pulse in start v%0d", v), int'(lsc[s + 8]), int'(cp));
         chk($sformatf("R11 no pulse in stop v%0d", v), int'(lsc[p + exps / 2]), int'(cp));
         if (ce) begin
            chk($sformatf("R11 early half v%0d", v), int'(lsc[s + 20]), int'(cp ^ cph));
            chk($sformatf("R11 late half v%0d", v), int'(lsc[s + 28]), int'(cp ^ !cph));
         end else begin
            chk($sformatf("R9 disabled early half v%0d", v), int'(lsc[s + 20]), int'(cp));
            chk($sformatf("R9 disabled late half v%0d", v), int'(lsc[s + 28]), int'(cp));
         end
      end

      // R4 and R5: busy during a frame, control change mid-frame ignored
      ctrl = 6'b000000;
      repeat (3) @(negedge clk);
      clear_log();
      send(8'h81);
      ctrl = 6'b010000;
      repeat (40) @(negedge clk);
      chk("R4 ready low mid-frame", int'(ready), 0);
      chk("R4 busy high mid-frame", int'(busy), 1);
      send(8'h42);
      wait_idle();
      s = find_low(0);
      if (s < 0) s = 0;
      chk("R5 first frame keeps 1-bit stop", run_len(s + 144, 1'b1), 16);

      // R6 break with line-bus mode on
      ctrl = 6'b100000;
      repeat (3) @(negedge clk);
      clear_log();
      pulse_break();
      wait_idle();
      repeat (100) @(negedge clk);
      s = find_low(0);
      chk("R6 break found", int'(s >= 0), 1);
      if (s < 0) s = 0;
      chk("R6 break low ticks", run_len(s, 1'b0), 208);
      chk("R6 gap before done at least 16", int'(done_at - (s + 208) >= 16), 1);
      chk("R6 single done pulse", ndone, 1);
      chk("R6 line high after break", int'(tx), 1);

      // R7 break request dropped with line-bus mode off
      ctrl = 6'b000000;
      repeat (3) @(negedge clk);
      clear_log();
      pulse_break();
      repeat (1200) @(negedge clk);
      chk("R7 no low on line", find_low(0), -1);
      chk("R7 no done pulse", ndone, 0);
      chk("R7 busy stays low", int'(busy), 0);

      // R8 pending break beats waiting byte
      ctrl = 6'b100000;
      repeat (3) @(negedge clk);
      clear_log();
      send(8'h00);
      repeat (160) @(negedge clk);
      pulse_break();
      send(8'hC3);
      wait_idle();
      s = find_low(0);
      if (s < 0) s = 0;
      s2 = find_low(s + 144);
      chk("R8 first gap is stop", s2 - (s + 144), 16);
      if (s2 < 0) s2 = 0;
      chk("R8 break sent first", run_len(s2, 1'b0), 208);
      s3 = find_low(s2 + 208);
      if (s3 < 0) s3 = 0;
      chk("R8 byte follows break", int'(ltx[s3 + 24]), 1);
      chk("R8 byte bit 2 after break", int'(ltx[s3 + 56]), 0);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
   end

endmodule